// File: doc/BRIEF.md
# Multiplexed Grayscale PWM Generator

This block produces 48 active-high output enables for a row-scanned LED panel. A shared grayscale counter steps once on every grayscale clock edge. Each channel's enable stays high while the counter is below that channel's 16-bit grayscale value for the scan line being shown. The channels form three colour groups of 16: red, green and blue.

Grayscale values live in an on-chip display memory. The memory holds one value per channel per scan line for up to 32 lines, and it exists twice. One copy feeds the comparators while the other accepts writes. A swap request exchanges the two copies, but only at a frame boundary, so a frame never shows a mix of old and new data.

A line ends in one of two ways: the counter runs out after 65536 clocks, or an external line-advance pulse arrives. At that point the counter restarts and the next line's values are selected. The number of scan lines can be set anywhere from 1 to 32. A power-save flag reports a completed line in which no output was ever on.

Top module: `gs_mux_pwm`

## Requirements
- R1: There are 48 channels. Channel c drives `ch_on[c]` and belongs to colour group c/16 (0 red, 1 green, 2 blue). A write names its channel by this index on `wr_ch`.
- R2: `ch_on[c]` is high exactly when the grayscale counter is below the value stored for channel c, current line, display bank. A value of 0 keeps the output low for the whole line. A value of 16'hFFFF keeps it high in every cycle except counter value 16'hFFFF.
- R3: After reset the counter, line and display bank are 0, the memory holds zeros, all outputs are low and `pwr_save` is low. The counter then increases by one on each grayscale clock edge that does not end a line.
- R4: A line ends on an edge where `line_adv` is high or the counter equals 16'hFFFF. On that edge the counter returns to 0. The line number (`cur_line`) advances by one, or returns to 0 when the current line is greater than or equal to `last_line`. The scan therefore covers `last_line`+1 lines, from 1 to 32.
- R5: A write (`wr_en` high) stores `wr_data` at (`wr_line`, `wr_ch`) in the bank that is not displayed. It cannot change the outputs until a swap makes that bank the display bank.
- R6: A `swap_req` pulse is held pending and toggles `disp_bank` on the next frame end, which is a line end while the current line is at or above `last_line`. A request in the frame-end cycle itself takes effect on that same edge. `disp_bank` changes at no other time.
- R7: Within a line, an output that is low stays low until the line ends.
- R8: On each line end, `pwr_save` becomes high if no output was high in any cycle of that line, the ending cycle included, and low otherwise. Between line ends it falls on the edge after any output is high.
- R9: A write whose `wr_ch` is 48 or more is ignored and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gs_clk | input | 1 | Grayscale reference clock; every edge steps the counter |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe into the non-displayed bank |
| wr_line | input | 5 | Scan line of the write |
| wr_ch | input | 6 | Channel index of the write (0..47 valid) |
| wr_data | input | 16 | Grayscale value written |
| swap_req | input | 1 | Request to exchange banks at the next frame end |
| line_adv | input | 1 | Ends the current line early |
| last_line | input | 5 | Index of the final scan line (lines in scan minus one) |
| ch_on | output | 48 | Channel output enables, bit c for channel c |
| cur_line | output | 5 | Scan line currently shown |
| disp_bank | output | 1 | Bank currently shown |
| pwr_save | output | 1 | No output was on during the last full line |

## Verification
The embedded assertions check the cycle-level rules on every edge:
- counter stepping and restart at a line end;
- line hold, increment and return to zero;
- the display bank holding still outside frame ends, and toggling when a swap request arrives at one;
- writes never targeting the shown bank;
- an off output staying off within a line;
- the power-save flag rising only at a line end and falling once an output turns on.

Whether each output compares against the right value cannot be shown by a property alone. That covers the right line, bank and channel, the effect of writes made before a swap, and ignored out-of-range writes. These are shown by the bench's scenarios against its own memory and scan model: filling a hidden bank, mid-frame swaps, an all-zero line, a natural counter wrap, and scans of 1, 2, 4 and 32 lines.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

  // Default geometry of the generator
  localparam int unsigned DEF_CH_PER_GROUP = 16;
  localparam int unsigned DEF_GROUPS       = 3;
  localparam int unsigned DEF_GS_W         = 16;
  localparam int unsigned DEF_LINES        = 32;

  // Colour group of a channel: index / channels-per-group
  typedef enum logic [1:0] {
    GRP_RED   = 2'd0,
    GRP_GREEN = 2'd1,
    GRP_BLUE  = 2'd2
  } color_grp_e;

  function automatic color_grp_e group_of(input int unsigned ch, input int unsigned per_group);
    return color_grp_e'(ch / per_group);
  endfunction

endpackage

// File: rtl/gs_line_timer.sv
module gs_line_timer #(
  parameter int unsigned GS_W   = 16,
  parameter int unsigned LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_adv,
  input  logic [LINE_W-1:0] last_line,
  input  logic              swap_req,
  output logic [GS_W-1:0]   cnt,
  output logic [LINE_W-1:0] line,
  output logic              line_end,
  output logic              frame_end,
  output logic              disp_bank
);

  localparam logic [GS_W-1:0] CNT_MAX = {GS_W{1'b1}};

  logic swap_pend;

  function automatic logic [LINE_W-1:0] next_line(input logic [LINE_W-1:0] cur,
                                                  input logic [LINE_W-1:0] last);
    if (cur >= last) return '0;
    return cur + 1'b1;
  endfunction

  function automatic logic [GS_W-1:0] step_cnt(input logic [GS_W-1:0] cur, input logic restart);
    if (restart) return '0;
    return cur + 1'b1;
  endfunction

  assign line_end  = line_adv || (cnt == CNT_MAX);
  assign frame_end = line_end && (line >= last_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      line      <= '0;
      disp_bank <= 1'b0;
      swap_pend <= 1'b0;
    end else begin
      cnt <= step_cnt(cnt, line_end);
      if (line_end) line <= next_line(line, last_line);
      if (frame_end) begin
        if (swap_pend || swap_req) disp_bank <= ~disp_bank;
        swap_pend <= 1'b0;
      end else if (swap_req) begin
        swap_pend <= 1'b1;
      end
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> cnt == GS_W'($past(cnt) + 1'b1));                       // R3
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> cnt == '0);                                               // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line));                                          // R4
  AST_LINE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end) |=> line == LINE_W'($past(line) + 1'b1));     // R4
  AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> line == '0);                                             // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(disp_bank));                                    // R6
  AST_SWAP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && swap_req) |=> disp_bank != $past(disp_bank));            // R6

endmodule

// File: rtl/gs_display_mem.sv
module gs_display_mem #(
  parameter int unsigned NCH    = 48,
  parameter int unsigned GS_W   = 16,
  parameter int unsigned LINES  = 32,
  parameter int unsigned LINE_W = 5,
  parameter int unsigned CH_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [LINE_W-1:0]         wr_line,
  input  logic [CH_W-1:0]           wr_ch,
  input  logic [GS_W-1:0]           wr_data,
  input  logic                      rd_bank,
  input  logic [LINE_W-1:0]         rd_line,
  output logic [NCH-1:0][GS_W-1:0]  rd_vals
);

  localparam int unsigned BANKS = 2;

  logic [GS_W-1:0] mem [BANKS][LINES][NCH];
  logic            wr_bank;
  logic            wr_ok;

  // Writes always go to the bank that is not being shown
  assign wr_bank = ~rd_bank;
  assign wr_ok   = wr_en && (int'(wr_ch) < NCH) && (int'(wr_line) < LINES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int l = 0; l < LINES; l++)
          for (int c = 0; c < NCH; c++)
            mem[b][l][c] <= '0;
    end else if (wr_ok) begin
      mem[wr_bank][wr_line][wr_ch] <= wr_data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rd
    assign rd_vals[c] = mem[rd_bank][rd_line][c];
  end

  AST_WR_HIDDEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> wr_bank != rd_bank);                                         // R5
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_ch) >= NCH) |-> !wr_ok);                             // R9

endmodule

// File: rtl/gs_channel_cmp.sv
module gs_channel_cmp #(
  parameter int unsigned NCH  = 48,
  parameter int unsigned GS_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GS_W-1:0]          cnt,
  input  logic [NCH-1:0][GS_W-1:0] vals,
  input  logic                     line_end,
  output logic [NCH-1:0]           ch_on
);

  function automatic logic pwm_active(input logic [GS_W-1:0] count, input logic [GS_W-1:0] level);
    return count < level;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_on[c] = pwm_active(cnt, vals[c]);

    AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_end && !ch_on[c]) |=> !ch_on[c]);                             // R7
  end

endmodule

// File: rtl/gs_pwr_monitor.sv
module gs_pwr_monitor #(
  parameter int unsigned NCH = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_on,
  input  logic           line_end,
  output logic           pwr_save
);

  logic any_on;
  logic seen_on;

  assign any_on = |ch_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_on  <= 1'b0;
      pwr_save <= 1'b0;
    end else if (line_end) begin
      pwr_save <= !(seen_on || any_on);
      seen_on  <= 1'b0;
    end else begin
      seen_on <= seen_on || any_on;
      if (any_on) pwr_save <= 1'b0;
    end
  end

  AST_PS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_save && any_on && !line_end) |=> !pwr_save);                      // R8
  AST_PS_RISES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_save) |-> $past(line_end));                                  // R8

endmodule

// File: rtl/gs_mux_pwm.sv
module gs_mux_pwm #(
  parameter int unsigned CH_PER_GROUP = gs_pwm_pkg::DEF_CH_PER_GROUP,
  parameter int unsigned GROUPS       = gs_pwm_pkg::DEF_GROUPS,
  parameter int unsigned GS_W         = gs_pwm_pkg::DEF_GS_W,
  parameter int unsigned LINES        = gs_pwm_pkg::DEF_LINES,
  localparam int unsigned NCH         = CH_PER_GROUP * GROUPS,
  localparam int unsigned LINE_W      = $clog2(LINES),
  localparam int unsigned CH_W        = $clog2(NCH)
) (
  input  logic              gs_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [GS_W-1:0]   wr_data,
  input  logic              swap_req,
  input  logic              line_adv,
  input  logic [LINE_W-1:0] last_line,
  output logic [NCH-1:0]    ch_on,
  output logic [LINE_W-1:0] cur_line,
  output logic              disp_bank,
  output logic              pwr_save
);

  // Internal events brought out as named wires
  logic [GS_W-1:0]          gs_cnt;
  logic                     line_end;
  logic                     frame_end;
  logic [NCH-1:0][GS_W-1:0] line_vals;

  gs_line_timer #(
    .GS_W   (GS_W),
    .LINE_W (LINE_W)
  ) u_timer (
    .clk       (gs_clk),
    .rst_n     (rst_n),
    .line_adv  (line_adv),
    .last_line (last_line),
    .swap_req  (swap_req),
    .cnt       (gs_cnt),
    .line      (cur_line),
    .line_end  (line_end),
    .frame_end (frame_end),
    .disp_bank (disp_bank)
  );

  gs_display_mem #(
    .NCH    (NCH),
    .GS_W   (GS_W),
    .LINES  (LINES),
    .LINE_W (LINE_W),
    .CH_W   (CH_W)
  ) u_mem (
    .clk     (gs_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_line (wr_line),
    .wr_ch   (wr_ch),
    .wr_data (wr_data),
    .rd_bank (disp_bank),
    .rd_line (cur_line),
    .rd_vals (line_vals)
  );

  gs_channel_cmp #(
    .NCH  (NCH),
    .GS_W (GS_W)
  ) u_cmp (
    .clk      (gs_clk),
    .rst_n    (rst_n),
    .cnt      (gs_cnt),
    .vals     (line_vals),
    .line_end (line_end),
    .ch_on    (ch_on)
  );

  gs_pwr_monitor #(
    .NCH (NCH)
  ) u_pwr (
    .clk      (gs_clk),
    .rst_n    (rst_n),
    .ch_on    (ch_on),
    .line_end (line_end),
    .pwr_save (pwr_save)
  );

  AST_FRAME_IS_LINE_END: assert property (@(posedge gs_clk) disable iff (!rst_n)
    frame_end |-> line_end);                                               // R6
  AST_RESTART_ALL_LIT: assert property (@(posedge gs_clk) disable iff (!rst_n)
    (line_end && !frame_end) |=> cur_line != '0);                          // R4

endmodule

// File: tb/gs_mux_pwm_bench.sv
`timescale 1ns/1ps
module gs_mux_pwm_bench;

  localparam int  NCH   = 48;
  localparam int  LINES = 32;
  localparam time TCK   = 8ns;   // 125 MHz

  logic        gs_clk = 1'b0;
  logic        rst_n  = 1'b0;
  logic        wr_en  = 1'b0;
  logic [4:0]  wr_line = '0;
  logic [5:0]  wr_ch   = '0;
  logic [15:0] wr_data = '0;
  logic        swap_req = 1'b0;
  logic        line_adv = 1'b0;
  logic [4:0]  last_line = 5'd3;
  logic [NCH-1:0] ch_on;
  logic [4:0]  cur_line;
  logic        disp_bank;
  logic        pwr_save;

  gs_mux_pwm u_gs_mux_pwm (
    .gs_clk, .rst_n, .wr_en, .wr_line, .wr_ch, .wr_data,
    .swap_req, .line_adv, .last_line,
    .ch_on, .cur_line, .disp_bank, .pwr_save
  );

  always #(TCK/2) gs_clk = ~gs_clk;

  int vecs = 0;
  int errs = 0;

  // Bench model of memory and scan state
  bit [15:0] bm [2][LINES][NCH];
  int m_cnt, m_line, m_bank, m_pend, m_seen, m_ps;

  function automatic logic [NCH-1:0] model_on();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = (m_cnt < int'(bm[m_bank][m_line][c]));
    return v;
  endfunction

  function automatic logic [15:0] pick_gs();
    int r = $urandom_range(0, 9);
    if (r == 0) return 16'h0000;
    if (r == 1) return 16'hFFFF;
    if (r == 2) return 16'($urandom_range(1, 3));
    return 16'($urandom_range(0, 90));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One clock: advance the model with the inputs now driven, then compare
  task automatic tick();
    logic [NCH-1:0] cur;
    bit any_on, le, fe;
    cur    = model_on();
    any_on = |cur;
    le     = line_adv || (m_cnt == 65535);
    fe     = le && (m_line >= int'(last_line));
    if (wr_en && int'(wr_ch) < NCH) bm[1 - m_bank][wr_line][wr_ch] = wr_data;   // R5, R9
    if (le) begin
      m_ps   = !(m_seen || any_on);
      m_seen = 0;
    end else begin
      m_seen = m_seen || any_on;
      if (any_on) m_ps = 0;
    end
    m_cnt = le ? 0 : m_cnt + 1;                                   // R3
    if (le) m_line = (m_line >= int'(last_line)) ? 0 : m_line + 1;
    if (fe) begin
      if (m_pend || swap_req) m_bank = 1 - m_bank;
      m_pend = 0;
    end else if (swap_req) m_pend = 1;
    @(posedge gs_clk);
    @(negedge gs_clk);
    check("R2/R1 ch_on", 64'(ch_on), 64'(model_on()));
    check("R4 cur_line", 64'(cur_line), 64'(m_line));
    check("R6 disp_bank", 64'(disp_bank), 64'(m_bank));
    check("R8 pwr_save", 64'(pwr_save), 64'(m_ps));
  endtask

  task automatic clear_inputs();
    wr_en = 1'b0; swap_req = 1'b0; line_adv = 1'b0;
  endtask

  task automatic write_one(int line, int ch, logic [15:0] val, int adv_period, ref int k);
    wr_en = 1'b1; wr_line = 5'(line); wr_ch = 6'(ch); wr_data = val;
    line_adv = ((k % adv_period) == adv_period - 1);
    tick();
    k++;
    clear_inputs();
  endtask

  task automatic run_random(int n, int adv_lo, int adv_hi, int wr_pct, int swap_pct);
    int left = $urandom_range(adv_lo, adv_hi);
    for (int i = 0; i < n; i++) begin
      clear_inputs();
      left--;
      if (left <= 0) begin
        line_adv = 1'b1;
        left = $urandom_range(adv_lo, adv_hi);
      end
      if ($urandom_range(0, 99) < wr_pct) begin
        wr_en   = 1'b1;
        wr_line = 5'($urandom_range(0, LINES - 1));
        wr_ch   = 6'($urandom_range(0, 63));   // includes ignored 48..63, R9
        wr_data = pick_gs();
      end
      if ($urandom_range(0, 999) < swap_pct) swap_req = 1'b1;
      tick();
    end
    clear_inputs();
  endtask

  // Watchdog: an expired run counts as a failure and still reports
  initial begin
    #(TCK * 195000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h5EED_0042));
    m_cnt = 0; m_line = 0; m_bank = 0; m_pend = 0; m_seen = 0; m_ps = 0;

    // Reset state (R3)
    repeat (3) @(negedge gs_clk);
    check("R3 reset ch_on", 64'(ch_on), 64'd0);
    check("R3 reset cur_line", 64'(cur_line), 64'd0);
    check("R3 reset disp_bank", 64'(disp_bank), 64'd0);
    check("R3 reset pwr_save", 64'(pwr_save), 64'd0);
    rst_n = 1'b1;

    // Fill hidden bank, 4-line scan, display still all zero -> power save (R5, R8)
    last_line = 5'd3;
    k = 0;
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < NCH; c++) write_one(l, c, pick_gs(), 40, k);
    // Out-of-range channel writes must not disturb anything (R9)
    for (int c = NCH; c < 64; c++) write_one($urandom_range(0, 3), c, 16'hFFFF, 40, k);

    // Swap pulse mid-frame: takes effect at the frame end (R6)
    swap_req = 1'b1; tick(); clear_inputs();
    run_random(400, 20, 80, 0, 0);

    // Mixed random traffic with concurrent writes and swaps (R2, R7)
    run_random(20000, 15, 90, 40, 8);
    last_line = 5'd1;
    run_random(5000, 10, 50, 40, 10);

    // Directed all-zero line in a 2-line scan (R8)
    k = 0;
    for (int c = 0; c < NCH; c++) write_one(0, c, 16'h0000, 30, k);
    for (int c = 0; c < NCH; c++) write_one(1, c, pick_gs(), 30, k);
    swap_req = 1'b1; tick(); clear_inputs();
    run_random(600, 25, 35, 0, 0);

    // Natural counter wrap in a single-line scan (R4, R2 with 16'hFFFF)
    last_line = 5'd0;
    k = 0;
    for (int c = 0; c < NCH; c++)
      write_one(0, c, (c % 3 == 0) ? 16'hFFFF : (c % 3 == 1) ? 16'h8000 : 16'h0000, 1000000, k);
    swap_req = 1'b1; line_adv = 1'b1; tick(); clear_inputs();
    for (int i = 0; i < 65700; i++) tick();

    // Full 32-line scan (R1, R4)
    last_line = 5'd31;
    run_random(20000, 8, 60, 50, 6);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule